// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This block performs 32-bit integer multiplication and division, signed or unsigned, over a sequence of one-bit iteration steps. A single-cycle start pulse, qualified by a two-bit operation code, captures both operands. The block then runs a fixed number of steps while a busy flag stays high. Multiplication accumulates the multiplicand under control of each multiplier bit and shifts right. Division shifts the partial remainder left and makes a trial subtraction of the divisor, which settles one quotient bit per step.

Results go to two dedicated result registers, a high word and a low word, and each has its own read port. A multiply leaves the double-width product split across the two registers. A divide leaves the quotient in the low word and the remainder in the high word. Signed operations use the operand magnitudes and correct the signs afterwards. The unit raises no overflow indication. A zero divisor produces a fixed, documented result in the normal number of cycles, and software is expected to detect that case itself.

Top module: `muldiv_unit`

## Requirements
- R1: While reset is held and directly after it, busy_o and done_o are 0 and both hi_o and lo_o read 0.
- R2: A start_i pulse while busy_o is 0 raises busy_o on the next cycle. busy_o stays high for exactly W cycles. On the cycle it falls, done_o is 1 for that single cycle and the new results are visible on hi_o and lo_o.
- R3: A start_i pulse while busy_o is 1 is ignored: the running operation keeps its operands, its results and its cycle count.
- R4: op_i = 2'b00 (unsigned multiply) leaves the 2W-bit unsigned product with its upper half on hi_o and its lower half on lo_o.
- R5: op_i = 2'b01 (signed multiply) does the same for the two's-complement product of the operands.
- R6: op_i = 2'b10 (unsigned divide) with b_i nonzero leaves the quotient a_i / b_i on lo_o and the remainder on hi_o.
- R7: op_i = 2'b11 (signed divide) with b_i nonzero truncates toward zero. The quotient is negative exactly when the operand signs differ, and the remainder takes the sign of a_i.
- R8: With b_i = 0, in either divide mode, the operation takes the normal W cycles and leaves lo_o all ones and hi_o equal to a_i.
- R9: A signed divide of the most negative value by -1 raises no flag and wraps: lo_o equals the most negative value and hi_o is 0.
- R10: hi_o and lo_o hold their values from one completion to the next, including while a new operation is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| op_i | input | 2 | Operation: bit 1 selects divide, bit 0 selects signed |
| a_i | input | W | Multiplier or dividend |
| b_i | input | W | Multiplicand or divisor |
| busy_o | output | 1 | High while an operation is iterating |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | W | High result word: product upper half or remainder |
| lo_o | output | W | Low result word: product lower half or quotient |

## Verification
The bench builds the unit with its default width of W = 32. At this width it can reach the full-range corners: the all-ones square, the most negative value squared, the most negative value divided by -1, and a dividend with its top bit set and a zero divisor. Every operation is timed edge by edge against the W-cycle busy window. Stray start pulses and mid-operation reads of hi_o and lo_o show that the running work and the held results stay untouched.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MULU = 2'b00,
    OP_MULS = 2'b01,
    OP_DIVU = 2'b10,
    OP_DIVS = 2'b11
  } md_op_e;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl #(
  parameter int W = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          busy_q, done_q;
  logic [CW-1:0] cnt_q;

  assign load_o = start_i && !busy_q;
  assign step_o = busy_q;
  assign last_o = busy_q && (cnt_q == LAST);
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= last_o;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (last_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_finish_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (done_o && !busy_o));
  p_ignore_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last_o) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/muldiv_prep.sv
module muldiv_prep
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  md_op_e       op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         neg_lo_o,
  output logic         neg_hi_o,
  output logic         zero_div_o
);
  logic is_signed, is_div, sa, sb;

  assign is_signed  = op_i[0];
  assign is_div     = op_i[1];
  assign sa         = is_signed && a_i[W-1];
  assign sb         = is_signed && b_i[W-1];
  assign zero_div_o = (b_i == '0);

  assign mag_a_o = sa ? (~a_i + 1'b1) : a_i;
  assign mag_b_o = sb ? (~b_i + 1'b1) : b_i;

  // mul: neg_lo marks the whole product; div: quotient sign, kept positive on zero divisor
  always_comb begin
    if (is_div) begin
      neg_lo_o = (sa ^ sb) && !zero_div_o;
      neg_hi_o = sa;
    end else begin
      neg_lo_o = sa ^ sb;
      neg_hi_o = 1'b0;
    end
  end
endmodule

// File: rtl/muldiv_core.sv
module muldiv_core #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         is_div_i,
  input  logic [W-1:0] mag_a_i,
  input  logic [W-1:0] mag_b_i,
  output logic [W-1:0] nxt_hi_o,
  output logic [W-1:0] nxt_lo_o
);
  logic [W-1:0] upper_q, lower_q, opnd_q;
  logic         div_q;

  logic [W:0]   mul_sum;
  logic [W:0]   shifted;
  logic [W+1:0] diff;
  logic         fits;

  always_comb begin
    mul_sum = {1'b0, upper_q} + (lower_q[0] ? {1'b0, opnd_q} : '0);
    shifted = {upper_q, lower_q[W-1]};
    diff    = {1'b0, shifted} - {2'b00, opnd_q};
    fits    = !diff[W+1];
    if (div_q) begin
      nxt_hi_o = fits ? diff[W-1:0] : shifted[W-1:0];
      nxt_lo_o = {lower_q[W-2:0], fits};
    end else begin
      nxt_hi_o = mul_sum[W:1];
      nxt_lo_o = {mul_sum[0], lower_q[W-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q <= '0;
      lower_q <= '0;
      opnd_q  <= '0;
      div_q   <= 1'b0;
    end else if (load_i) begin
      upper_q <= '0;
      lower_q <= mag_a_i;
      opnd_q  <= mag_b_i;
      div_q   <= is_div_i;
    end else if (step_i) begin
      upper_q <= nxt_hi_o;
      lower_q <= nxt_lo_o;
    end
  end

  // R6: remainder held below the divisor after every step
  p_rem_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && div_q && opnd_q != '0) |=> (upper_q < opnd_q));
endmodule

// File: rtl/muldiv_fix.sv
module muldiv_fix #(
  parameter int W = 32
) (
  input  logic         is_div_i,
  input  logic         neg_lo_i,
  input  logic         neg_hi_i,
  input  logic [W-1:0] raw_hi_i,
  input  logic [W-1:0] raw_lo_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic [2*W-1:0] prod_neg;

  assign prod_neg = ~{raw_hi_i, raw_lo_i} + 1'b1;

  always_comb begin
    if (is_div_i) begin
      lo_o = neg_lo_i ? (~raw_lo_i + 1'b1) : raw_lo_i;
      hi_o = neg_hi_i ? (~raw_hi_i + 1'b1) : raw_hi_i;
    end else if (neg_lo_i) begin
      {hi_o, lo_o} = prod_neg;
    end else begin
      hi_o = raw_hi_i;
      lo_o = raw_lo_i;
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic         load, step, last;
  logic [W-1:0] mag_a, mag_b, nxt_hi, nxt_lo, fix_hi, fix_lo;
  logic         neg_lo, neg_hi, zero_div;
  logic         div_q, neg_lo_q, neg_hi_q, zdiv_q;
  logic [W-1:0] hi_q, lo_q;
  md_op_e       op;

  assign op = md_op_e'(op_i);

  muldiv_ctrl #(.W(W)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .load_o(load), .step_o(step), .last_o(last),
    .busy_o, .done_o
  );

  muldiv_prep #(.W(W)) u_prep (
    .op_i(op), .a_i, .b_i,
    .mag_a_o(mag_a), .mag_b_o(mag_b),
    .neg_lo_o(neg_lo), .neg_hi_o(neg_hi), .zero_div_o(zero_div)
  );

  muldiv_core #(.W(W)) u_core (
    .clk_i, .rst_ni,
    .load_i(load), .step_i(step), .is_div_i(op_i[1]),
    .mag_a_i(mag_a), .mag_b_i(mag_b),
    .nxt_hi_o(nxt_hi), .nxt_lo_o(nxt_lo)
  );

  muldiv_fix #(.W(W)) u_fix (
    .is_div_i(div_q), .neg_lo_i(neg_lo_q), .neg_hi_i(neg_hi_q),
    .raw_hi_i(nxt_hi), .raw_lo_i(nxt_lo),
    .hi_o(fix_hi), .lo_o(fix_lo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= 1'b0;
      neg_lo_q <= 1'b0;
      neg_hi_q <= 1'b0;
      zdiv_q   <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else begin
      if (load) begin
        div_q    <= op_i[1];
        neg_lo_q <= neg_lo;
        neg_hi_q <= neg_hi;
        zdiv_q   <= zero_div;
      end
      if (last) begin
        hi_q <= fix_hi;
        lo_q <= fix_lo;
      end
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(hi_o) && $stable(lo_o)));
  p_zero_div_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_q && zdiv_q) |-> (lo_o == '1));
endmodule

// File: tb/muldiv_unit_tb_top.sv
module muldiv_unit_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   op = 2'b00;
  logic [W-1:0] a = '0, b = '0;
  logic         busy, done;
  logic [W-1:0] hi, lo;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  muldiv_unit #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .a_i(a), .b_i(b), .busy_o(busy), .done_o(done), .hi_o(hi), .lo_o(lo)
  );

  task automatic check(input string req, input string what,
                       input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] model(input logic [1:0] o,
                                           input logic [W-1:0] x, input logic [W-1:0] y);
    logic signed [2*W-1:0] sx, sy, q, r;
    logic [2*W-1:0] res;
    sx = $signed({{W{x[W-1]}}, x});
    sy = $signed({{W{y[W-1]}}, y});
    case (o)
      2'b00: res = {{W{1'b0}}, x} * {{W{1'b0}}, y};
      2'b01: res = sx * sy;
      default: begin
        if (y == '0) res = {x, {W{1'b1}}};
        else if (o == 2'b10) res = {x % y, x / y};
        else begin
          q = sx / sy;
          r = sx % sy;
          res = {r[W-1:0], q[W-1:0]};
        end
      end
    endcase
    return res;
  endfunction

  // runs one operation; optional stray start mid-run and a hold check of previous results
  task automatic run_op(input string req, input logic [1:0] o,
                        input logic [W-1:0] x, input logic [W-1:0] y, input bit stray);
    logic [W-1:0] old_hi, old_lo;
    int cyc;
    old_hi = hi;
    old_lo = lo;
    @(negedge clk);
    op = o; a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a = ~x; b = y + 1; op = ~o;
    check("R2", "busy after start", {63'b0, busy}, 64'd1);
    cyc = 0;
    while (!done && cyc < 100) begin
      if (stray && cyc == 5) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc++;
        check("R10", "hold during busy", {hi, lo}, {old_hi, old_lo});
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    check(stray ? "R3" : "R2", "cycles to done", 64'(cyc), 64'(W));
    check("R2", "busy low at done", {63'b0, busy}, 64'd0);
    check(req, "result hi:lo", {hi, lo}, model(o, x, y));
    @(negedge clk);
    check("R2", "done one cycle", {63'b0, done}, 64'd0);
    check(stray ? "R3" : "R2", "no extra run", {63'b0, busy}, 64'd0);
  endtask

  task automatic t_reset();
    #5;
    check("R1", "reset flags", {62'b0, busy, done}, 64'd0);
    check("R1", "reset hi:lo", {hi, lo}, 64'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "post-reset flags", {62'b0, busy, done}, 64'd0);
    check("R1", "post-reset hi:lo", {hi, lo}, 64'd0);
  endtask

  task automatic t_mulu();
    run_op("R4", 2'b00, 32'd1234, 32'd5678, 0);
    run_op("R4", 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    run_op("R4", 2'b00, 32'h0, 32'hDEAD_BEEF, 0);
  endtask

  task automatic t_muls();
    run_op("R5", 2'b01, 32'hFFFF_FFF9, 32'd3, 0);
    run_op("R5", 2'b01, 32'h8000_0000, 32'h8000_0000, 0);
    run_op("R5", 2'b01, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 0);
  endtask

  task automatic t_divu();
    run_op("R6", 2'b10, 32'd100, 32'd7, 0);
    run_op("R6", 2'b10, 32'hFFFF_FFFF, 32'd1, 0);
    run_op("R6", 2'b10, 32'd5, 32'hF000_0000, 0);
  endtask

  task automatic t_divs();
    run_op("R7", 2'b11, 32'hFFFF_FFF9, 32'd2, 0);
    run_op("R7", 2'b11, 32'd7, 32'hFFFF_FFFE, 0);
    run_op("R7", 2'b11, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 0);
  endtask

  task automatic t_zero();
    run_op("R8", 2'b10, 32'h8765_4321, 32'h0, 0);
    run_op("R8", 2'b11, 32'hFFFF_FF00, 32'h0, 0);
    check("R8", "signed zero-div lo all ones", {32'b0, lo}, {32'b0, 32'hFFFF_FFFF});
  endtask

  task automatic t_wrap();
    run_op("R9", 2'b11, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    check("R9", "wrapped quotient", {hi, lo}, {32'h0, 32'h8000_0000});
  endtask

  task automatic t_stray();
    run_op("R3", 2'b00, 32'd40000, 32'd90001, 1);
    run_op("R10", 2'b11, 32'hFFFF_0000, 32'd77, 1);
    repeat (3) @(negedge clk);
    check("R10", "idle hold", {hi, lo}, model(2'b11, 32'hFFFF_0000, 32'd77));
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_mulu();
    t_muls();
    t_divu();
    t_divs();
    t_zero();
    t_wrap();
    t_stray();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule